// File: doc/BRIEF.md
# Word-Addressed Sector Transfer Adapter

This block moves an arbitrary run of words between a requester's memory and a disk that can only transfer whole, aligned sectors. A request gives a disk word address, a word count from 1 up to `MAX_WORDS`, a memory word address and a direction. The block splits the request into one step per sector touched. Each step goes through a private one-sector buffer.

On a read, each step fetches the target sector into the buffer and copies only the needed slice into memory. On a write, each step fetches the sector, merges the new words from memory at the right offset, and writes the whole sector back. When a write step covers an entire aligned sector, the fetch is skipped because every word will be overwritten.

The first step starts at the offset of the word address within its sector. Every later step starts at offset zero of the next sector. A disk error ends the request early and reports how many words were fully transferred.

Top module: `sector_xfer_adapter`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `busy_o`, `done_o`, `err_o`, `sec_cmd_o`, `mem_req_o` and `sec_wr_valid_o` are all 0.
- R2: On a read request (`req_write_i`=0), memory word `maddr+i` receives disk word `daddr+i` for every i below the count. No other memory word changes.
- R3: On a write request (`req_write_i`=1), disk word `daddr+i` receives memory word `maddr+i` for every i below the count. Every other disk word keeps its value, including the untouched words of partly covered sectors.
- R4: Sector commands name sector `daddr / SEC_WORDS` first. Each later command names the same sector or the next one. A read request issues exactly one sector read (`sec_cmd_we_o`=0) per sector spanned.
- R5: A write request issues exactly one sector write (`sec_cmd_we_o`=1) per sector spanned. It issues a sector read only for sectors that the request covers partly.
- R6: A request that meets no disk error ends with `done_o` high for exactly one cycle, `err_o`=0 and `words_o` equal to the requested count.
- R7: If the disk completes any command of the step for sector E with `sec_err_i`=1, the request ends with `done_o` and `err_o`=1. `words_o` then equals the words of all steps before E, which is 0 when E is the first sector. The disk is not changed for sector E.
- R8: `req_valid_i` is ignored while `busy_o` is high. It starts no second transfer and alters neither memory nor disk.
- R9: Requests of exactly 1 word and of exactly `MAX_WORDS` words complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_write_i | input | 1 | 1 = memory to disk, 0 = disk to memory |
| req_daddr_i | input | DADDR_W (20) | Starting disk word address |
| req_count_i | input | CNT_W (13) | Word count, 1 to MAX_WORDS |
| req_maddr_i | input | MADDR_W (15) | Starting memory word address |
| busy_o | output | 1 | Request in progress |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | MADDR_W | Memory word address |
| mem_wdata_o | output | WORD_W (12) | Memory write data |
| mem_rdata_i | input | WORD_W | Memory read data, valid the cycle after a read strobe |
| sec_cmd_o | output | 1 | Sector command strobe |
| sec_cmd_we_o | output | 1 | Command is a sector write |
| sec_num_o | output | DADDR_W-log2(SEC_WORDS) | Sector number |
| sec_rd_valid_i | input | 1 | Sector read word valid, words in order |
| sec_rd_data_i | input | WORD_W | Sector read word |
| sec_wr_valid_o | output | 1 | Sector write word valid, words in order |
| sec_wr_data_o | output | WORD_W | Sector write word |
| sec_done_i | input | 1 | Sector command complete |
| sec_err_i | input | 1 | Completed command failed |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Request ended on a disk error; valid with done_o |
| words_o | output | CNT_W | Words transferred; valid with done_o |

## Verification
The bench builds the block with 16-word sectors, a 4096-word disk and an 8192-word memory, and keeps `MAX_WORDS` at 4096. The small sectors let short requests cross several sector boundaries, so first-step offsets, mid-run aligned sectors that skip the fetch, and ragged final sectors all occur within a few dozen words. They also let a full 4096-word request walk 256 steps within the cycle budget. Errors are injected on a chosen sector number. This covers a failing fetch on the first step, a failing write-back on a later, fully covered step, and a failing read partway through a run.

// File: rtl/sxa_pkg.sv
package sxa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BEGIN,
    ST_RD_FILL,
    ST_COPY,
    ST_WB_CMD,
    ST_WB,
    ST_STEP,
    ST_FIN
  } sxa_state_e;
endpackage

// File: rtl/sxa_sector_buf.sv
module sxa_sector_buf #(
  parameter int WORD_W = 12,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/sxa_step_calc.sv
module sxa_step_calc #(
  parameter int SEC_WORDS = 256,
  parameter int CNT_W     = 13,
  localparam int OFF_W    = $clog2(SEC_WORDS),
  localparam int LEN_W    = OFF_W + 1
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [CNT_W-1:0] remain_i,
  output logic [LEN_W-1:0] len_o,
  output logic             full_o,
  output logic             last_o
);
  logic [LEN_W-1:0] room;

  always_comb begin
    room = LEN_W'(SEC_WORDS) - {1'b0, off_i};
    if (remain_i < CNT_W'(room)) len_o = remain_i[LEN_W-1:0];
    else                         len_o = room;
    full_o = (off_i == '0) && (len_o == LEN_W'(SEC_WORDS));
    last_o = (remain_i == CNT_W'(len_o));
  end
endmodule

// File: rtl/sxa_walker.sv
module sxa_walker #(
  parameter int LEN_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             issue_o,
  output logic [LEN_W-1:0] idx_o,
  output logic             lat_valid_o,
  output logic [LEN_W-1:0] lat_idx_o,
  output logic             fin_o
);
  logic             run_q;
  logic [LEN_W-1:0] cnt_q, lim_q;

  assign issue_o = run_q && (cnt_q < lim_q);
  assign idx_o   = cnt_q;
  assign fin_o   = run_q && (cnt_q == lim_q) && !lat_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      cnt_q       <= '0;
      lim_q       <= '0;
      lat_valid_o <= 1'b0;
      lat_idx_o   <= '0;
    end else begin
      lat_valid_o <= issue_o;
      lat_idx_o   <= cnt_q;
      if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        lim_q <= len_i;
      end else if (fin_o) begin
        run_q <= 1'b0;
      end else if (issue_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: the index never runs past the slice length
  a_r2_idx_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q <= lim_q);
endmodule

// File: rtl/sector_xfer_adapter.sv
module sector_xfer_adapter
  import sxa_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int SEC_WORDS = 256,
  parameter int DADDR_W   = 20,
  parameter int MADDR_W   = 15,
  parameter int MAX_WORDS = 4096,
  localparam int OFF_W    = $clog2(SEC_WORDS),
  localparam int SEC_W    = DADDR_W - OFF_W,
  localparam int LEN_W    = OFF_W + 1,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [DADDR_W-1:0] req_daddr_i,
  input  logic [CNT_W-1:0]   req_count_i,
  input  logic [MADDR_W-1:0] req_maddr_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               sec_cmd_o,
  output logic               sec_cmd_we_o,
  output logic [SEC_W-1:0]   sec_num_o,
  input  logic               sec_rd_valid_i,
  input  logic [WORD_W-1:0]  sec_rd_data_i,
  output logic               sec_wr_valid_o,
  output logic [WORD_W-1:0]  sec_wr_data_o,
  input  logic               sec_done_i,
  input  logic               sec_err_i,
  output logic               done_o,
  output logic               err_o,
  output logic [CNT_W-1:0]   words_o
);
  sxa_state_e state_q, state_d;

  logic [SEC_W-1:0]   sec_q;
  logic [OFF_W-1:0]   off_q, fill_q;
  logic [CNT_W-1:0]   remain_q, done_words_q;
  logic [MADDR_W-1:0] maddr_q;
  logic               we_q, err_q;

  logic [LEN_W-1:0] step_len;
  logic             step_full, step_last;

  logic             walk_start;
  logic [LEN_W-1:0] walk_len;
  logic             w_issue, w_lat, w_fin;
  logic [LEN_W-1:0] w_idx, w_lat_idx;

  logic              buf_we;
  logic [OFF_W-1:0]  buf_waddr, buf_raddr;
  logic [WORD_W-1:0] buf_wdata, buf_rdata;

  logic skip_fetch;

  sxa_step_calc #(.SEC_WORDS(SEC_WORDS), .CNT_W(CNT_W)) u_step (
    .off_i   (off_q),
    .remain_i(remain_q),
    .len_o   (step_len),
    .full_o  (step_full),
    .last_o  (step_last)
  );

  sxa_walker #(.LEN_W(LEN_W)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (walk_start),
    .len_i      (walk_len),
    .issue_o    (w_issue),
    .idx_o      (w_idx),
    .lat_valid_o(w_lat),
    .lat_idx_o  (w_lat_idx),
    .fin_o      (w_fin)
  );

  sxa_sector_buf #(.WORD_W(WORD_W), .DEPTH(SEC_WORDS)) u_buf (
    .clk_i  (clk_i),
    .we_i   (buf_we),
    .waddr_i(buf_waddr),
    .wdata_i(buf_wdata),
    .raddr_i(buf_raddr),
    .rdata_o(buf_rdata)
  );

  // whole aligned sector overwritten: no fetch needed
  assign skip_fetch = we_q && step_full;

  always_comb begin
    state_d    = state_q;
    walk_start = 1'b0;
    walk_len   = step_len;
    case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = ST_BEGIN;
      ST_BEGIN: begin
        if (skip_fetch) begin
          walk_start = 1'b1;
          state_d    = ST_COPY;
        end else begin
          state_d = ST_RD_FILL;
        end
      end
      ST_RD_FILL: begin
        if (sec_done_i) begin
          if (sec_err_i) state_d = ST_FIN;
          else begin
            walk_start = 1'b1;
            state_d    = ST_COPY;
          end
        end
      end
      ST_COPY:    if (w_fin) state_d = we_q ? ST_WB_CMD : ST_STEP;
      ST_WB_CMD: begin
        walk_start = 1'b1;
        walk_len   = LEN_W'(SEC_WORDS);
        state_d    = ST_WB;
      end
      ST_WB:      if (sec_done_i) state_d = sec_err_i ? ST_FIN : ST_STEP;
      ST_STEP:    state_d = step_last ? ST_FIN : ST_BEGIN;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sec_q        <= '0;
      off_q        <= '0;
      fill_q       <= '0;
      remain_q     <= '0;
      done_words_q <= '0;
      maddr_q      <= '0;
      we_q         <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            sec_q        <= req_daddr_i[DADDR_W-1:OFF_W];
            off_q        <= req_daddr_i[OFF_W-1:0];
            remain_q     <= req_count_i;
            maddr_q      <= req_maddr_i;
            we_q         <= req_write_i;
            done_words_q <= '0;
            err_q        <= 1'b0;
          end
        end
        ST_BEGIN: fill_q <= '0;
        ST_RD_FILL: begin
          if (sec_rd_valid_i) fill_q <= fill_q + 1'b1;
          if (sec_done_i && sec_err_i) err_q <= 1'b1;
        end
        ST_WB: if (sec_done_i && sec_err_i) err_q <= 1'b1;
        ST_STEP: begin
          done_words_q <= done_words_q + CNT_W'(step_len);
          remain_q     <= remain_q - CNT_W'(step_len);
          maddr_q      <= maddr_q + MADDR_W'(step_len);
          if (!step_last) begin
            sec_q <= sec_q + 1'b1;
            off_q <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  // buffer ports: fill from disk, merge from memory, drain to memory or disk
  always_comb begin
    buf_we    = 1'b0;
    buf_waddr = fill_q;
    buf_wdata = sec_rd_data_i;
    if (state_q == ST_RD_FILL && sec_rd_valid_i) begin
      buf_we = 1'b1;
    end else if (state_q == ST_COPY && we_q && w_lat) begin
      buf_we    = 1'b1;
      buf_waddr = off_q + w_lat_idx[OFF_W-1:0];
      buf_wdata = mem_rdata_i;
    end
    buf_raddr = (state_q == ST_WB) ? w_idx[OFF_W-1:0] : off_q + w_idx[OFF_W-1:0];
  end

  assign mem_req_o   = (state_q == ST_COPY) && (we_q ? w_issue : w_lat);
  assign mem_we_o    = (state_q == ST_COPY) && !we_q && w_lat;
  assign mem_addr_o  = maddr_q + MADDR_W'(we_q ? w_idx : w_lat_idx);
  assign mem_wdata_o = buf_rdata;

  assign sec_cmd_o      = (state_q == ST_BEGIN && !skip_fetch) || (state_q == ST_WB_CMD);
  assign sec_cmd_we_o   = (state_q == ST_WB_CMD);
  assign sec_num_o      = sec_q;
  assign sec_wr_valid_o = (state_q == ST_WB) && w_lat;
  assign sec_wr_data_o  = buf_rdata;

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_FIN);
  assign err_o   = err_q;
  assign words_o = done_words_q;

  // R3: a copied slice never leaves the current sector
  a_r3_slice_in_sector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COPY && w_issue) |-> ({1'b0, off_q} + w_idx) < LEN_W'(SEC_WORDS));

  // R3: the remaining count covers the step being retired
  a_r3_remain_covers_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STEP) |-> remain_q >= CNT_W'(step_len));

  // R4: a good fetch completes only after a whole sector arrived
  a_r4_fill_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_FILL && sec_done_i && !sec_err_i) |-> fill_q == '0);

  // R6: end of request is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7: the error flag rises only on a failed disk completion
  a_r7_err_from_disk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(sec_done_i && sec_err_i));

  // R8: no new request is latched while a transfer runs
  a_r8_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_FIN) |=> busy_o);
endmodule

// File: tb/sector_xfer_adapter_bench.sv
`timescale 1ns/1ps
module sector_xfer_adapter_bench;
  localparam int WORD_W    = 12;
  localparam int SEC_WORDS = 16;
  localparam int DADDR_W   = 12;
  localparam int MADDR_W   = 13;
  localparam int MAX_WORDS = 4096;
  localparam int OFF_W     = $clog2(SEC_WORDS);
  localparam int SEC_W     = DADDR_W - OFF_W;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int DISK_N    = 1 << DADDR_W;
  localparam int MEM_N     = 1 << MADDR_W;

  localparam int VEC_N = 11;
  localparam int V_WE [VEC_N] = '{0, 0, 0, 1, 1, 1, 0, 1, 1, 0, 1};
  localparam int V_DA [VEC_N] = '{5, 16, 30, 37, 64, 90, 200, 300, 512, 0, 1000};
  localparam int V_CNT[VEC_N] = '{1, 16, 40, 3, 32, 50, 100, 40, 32, 4096, 1};
  localparam int V_MA [VEC_N] = '{100, 200, 300, 50, 400, 500, 1000, 1200, 1300, 2048, 7000};
  localparam int V_ES [VEC_N] = '{-1, -1, -1, -1, -1, -1, 14, 18, 33, -1, -1};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic               req_valid = 1'b0, req_write = 1'b0;
  logic [DADDR_W-1:0] req_daddr = '0;
  logic [CNT_W-1:0]   req_count = '0;
  logic [MADDR_W-1:0] req_maddr = '0;
  logic               busy_o, mem_req_o, mem_we_o, sec_cmd_o, sec_cmd_we_o;
  logic [MADDR_W-1:0] mem_addr_o;
  logic [WORD_W-1:0]  mem_wdata_o, sec_wr_data_o;
  logic [WORD_W-1:0]  mem_rdata = '0, sec_rd_data = '0;
  logic [SEC_W-1:0]   sec_num_o;
  logic               sec_rd_valid = 1'b0, sec_done = 1'b0, sec_err = 1'b0;
  logic               sec_wr_valid_o, done_o, err_o;
  logic [CNT_W-1:0]   words_o;

  sector_xfer_adapter #(
    .WORD_W(WORD_W), .SEC_WORDS(SEC_WORDS), .DADDR_W(DADDR_W),
    .MADDR_W(MADDR_W), .MAX_WORDS(MAX_WORDS)
  ) u_sector_xfer_adapter (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_daddr_i(req_daddr),
    .req_count_i(req_count), .req_maddr_i(req_maddr), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata),
    .sec_cmd_o(sec_cmd_o), .sec_cmd_we_o(sec_cmd_we_o), .sec_num_o(sec_num_o),
    .sec_rd_valid_i(sec_rd_valid), .sec_rd_data_i(sec_rd_data),
    .sec_wr_valid_o(sec_wr_valid_o), .sec_wr_data_o(sec_wr_data_o),
    .sec_done_i(sec_done), .sec_err_i(sec_err),
    .done_o(done_o), .err_o(err_o), .words_o(words_o)
  );

  logic [WORD_W-1:0] disk [DISK_N];
  logic [WORD_W-1:0] ref_disk [DISK_N];
  logic [WORD_W-1:0] mem [MEM_N];
  logic [WORD_W-1:0] ref_mem [MEM_N];
  logic [WORD_W-1:0] tmp [SEC_WORDS];

  int n_chk = 0, n_fail = 0;
  int err_sector = -1;
  int rd_cmds = 0, wr_cmds = 0, last_sec = 0, first_sec = 0;
  bit first_cmd = 1'b1, seq_bad = 1'b0;

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
      else          mem_rdata <= mem[mem_addr_o];
    end
  end

  // disk model: whole-sector transfers only
  int m_st = 0, m_cnt = 0, m_del = 0, m_sec = 0;
  bit m_err = 1'b0;
  always @(posedge clk) begin
    sec_done     <= 1'b0;
    sec_err      <= 1'b0;
    sec_rd_valid <= 1'b0;
    case (m_st)
      0: if (sec_cmd_o) begin
        m_sec = int'(sec_num_o);
        m_err = (m_sec == err_sector);
        m_cnt = 0;
        m_del = 2;
        if (first_cmd) begin
          if (m_sec != first_sec) seq_bad = 1'b1;
          first_cmd = 1'b0;
        end else if (m_sec != last_sec && m_sec != last_sec + 1) seq_bad = 1'b1;
        last_sec = m_sec;
        if (sec_cmd_we_o) begin wr_cmds++; m_st = 2; end
        else begin rd_cmds++; m_st = 1; end
      end
      1: begin
        if (m_del > 0) m_del--;
        else if (m_err) begin sec_done <= 1'b1; sec_err <= 1'b1; m_st = 0; end
        else m_st = 3;
      end
      3: begin
        sec_rd_valid <= 1'b1;
        sec_rd_data  <= disk[m_sec * SEC_WORDS + m_cnt];
        m_cnt++;
        if (m_cnt == SEC_WORDS) m_st = 4;
      end
      4: begin sec_done <= 1'b1; m_st = 0; end
      2: if (sec_wr_valid_o) begin
        tmp[m_cnt] = sec_wr_data_o;
        m_cnt++;
        if (m_cnt == SEC_WORDS) m_st = 5;
      end
      5: begin
        if (!m_err) for (int i = 0; i < SEC_WORDS; i++) disk[m_sec * SEC_WORDS + i] = tmp[i];
        sec_done <= 1'b1;
        sec_err  <= m_err;
        m_st = 0;
      end
      default: m_st = 0;
    endcase
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int mem_diffs();
    int d = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) d++;
    return d;
  endfunction

  function automatic int disk_diffs();
    int d = 0;
    for (int i = 0; i < DISK_N; i++) if (disk[i] !== ref_disk[i]) d++;
    return d;
  endfunction

  task automatic wait_done();
    int cyc = 0;
    while (!done_o && cyc < 30000) begin @(negedge clk); cyc++; end
    if (!done_o) begin
      check(1'b0, "R6", "watchdog expired waiting for done", cyc, 0);
      finish_up();
    end
  endtask

  task automatic run_xfer(input int we, input int da, input int cnt, input int ma, input int es);
    int s0 = da / SEC_WORDS;
    int sl = (da + cnt - 1) / SEC_WORDS;
    int expw, exp_rd = 0, exp_wr = 0;
    bit experr;
    string rq;
    if (es >= s0 && es <= sl) begin
      experr = 1'b1;
      expw = (es == s0) ? 0 : es * SEC_WORDS - da;
    end else begin
      experr = 1'b0;
      expw = cnt;
    end
    for (int s = s0; s <= sl; s++) begin
      if (we != 0) begin
        exp_wr++;
        if (!((s * SEC_WORDS >= da) && ((s + 1) * SEC_WORDS <= da + cnt))) exp_rd++;
      end else exp_rd++;
    end
    for (int i = 0; i < expw; i++) begin
      if (we != 0) ref_disk[da + i] = ref_mem[ma + i];
      else         ref_mem[ma + i] = ref_disk[da + i];
    end
    err_sector = es;
    rd_cmds = 0; wr_cmds = 0; first_cmd = 1'b1; seq_bad = 1'b0; first_sec = s0;
    @(negedge clk);
    req_valid = 1'b1; req_write = (we != 0);
    req_daddr = DADDR_W'(da); req_count = CNT_W'(cnt); req_maddr = MADDR_W'(ma);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    rq = experr ? "R7" : ((cnt == 1 || cnt == MAX_WORDS) ? "R9" : "R6");
    check(err_o == experr, rq, "error flag", int'(err_o), int'(experr));
    check(int'(words_o) == expw, rq, "words transferred", int'(words_o), expw);
    check(mem_diffs() == 0, (we != 0) ? "R3" : "R2", "memory words differing", mem_diffs(), 0);
    check(disk_diffs() == 0, (we != 0) ? "R3" : "R2", "disk words differing", disk_diffs(), 0);
    if (!experr) begin
      check(rd_cmds == exp_rd, (we != 0) ? "R5" : "R4", "sector reads", rd_cmds, exp_rd);
      check(wr_cmds == exp_wr, "R5", "sector writes", wr_cmds, exp_wr);
      check(!seq_bad, "R4", "sector order", int'(seq_bad), 0);
    end
    @(negedge clk);
    check(!done_o, "R6", "done pulse width", int'(done_o), 0);
  endtask

  initial begin
    int dones;
    for (int i = 0; i < DISK_N; i++) begin
      disk[i] = WORD_W'(i * 37 + 11);
      ref_disk[i] = disk[i];
    end
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = WORD_W'((i * 91 + 5) ^ 12'hA5A);
      ref_mem[i] = mem[i];
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !err_o, "R1", "status in reset", int'({busy_o, done_o, err_o}), 0);
    check(!sec_cmd_o && !mem_req_o && !sec_wr_valid_o, "R1", "strobes in reset",
          int'({sec_cmd_o, mem_req_o, sec_wr_valid_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R1", "idle after reset", int'({busy_o, done_o}), 0);

    // table of vectors: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < VEC_N; v++) run_xfer(V_WE[v], V_DA[v], V_CNT[v], V_MA[v], V_ES[v]);

    // R8: request held during a transfer is ignored
    for (int i = 0; i < 20; i++) ref_mem[3000 + i] = ref_disk[40 + i];
    err_sector = -1; first_cmd = 1'b1; seq_bad = 1'b0; first_sec = 2; rd_cmds = 0; wr_cmds = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_daddr = 40; req_count = 20; req_maddr = 3000;
    @(negedge clk);
    req_write = 1'b1; req_daddr = 0; req_count = 64; req_maddr = 0;
    repeat (15) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    check(int'(words_o) == 20, "R8", "words of first request", int'(words_o), 20);
    check(wr_cmds == 0, "R8", "sector writes from ignored request", wr_cmds, 0);
    dones = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    check(dones == 0 && !busy_o, "R8", "extra completions after ignored request", dones, 0);
    check(mem_diffs() == 0 && disk_diffs() == 0, "R8", "words disturbed", mem_diffs() + disk_diffs(), 0);

    finish_up();
  end
endmodule